// File: doc/BRIEF.md
# Conditional Compare Flag Unit

This block takes a 16-bit instruction word and checks whether it is one of nine compare forms. If it is, the block evaluates the chosen condition and stores the one-bit result in a condition flag. The condition is taken on two register operands, on one operand against zero, or on the R0 value against an 8-bit immediate that is sign-extended. The flag register is written at the clock edge that ends the cycle in which the compare is presented. Each compare therefore takes exactly one cycle.

The block also outputs the two register index fields taken from the instruction word. An external register file uses these to return the operand values in the same cycle. The block writes no general register and never changes an operand. Any word that is not a compare leaves the flag as it was.

Top module: `cmpflag_unit`

## Requirements
- R1: Word pattern 0011 nnnn mmmm 0000 yields flag = 1 exactly when Rn equals Rm.
- R2: Pattern 0011 nnnn mmmm 0011 yields 1 when Rn >= Rm as two's-complement values. Pattern 0011 nnnn mmmm 0111 yields 1 when Rn > Rm as two's-complement values.
- R3: Pattern 0011 nnnn mmmm 0110 yields 1 when Rn > Rm as unsigned values. Pattern 0011 nnnn mmmm 0010 yields 1 when Rn >= Rm as unsigned values.
- R4: Pattern 0100 nnnn 0001 0101 yields 1 when Rn is strictly above zero as a signed value. Pattern 0100 nnnn 0001 0001 yields 1 when Rn is zero or above.
- R5: Pattern 0010 nnnn mmmm 1100 yields 1 when at least one 8-bit lane of Rn equals the lane of Rm at the same position.
- R6: Pattern 1000 1000 iiii iiii yields 1 when R0 equals the 8-bit immediate i sign-extended to the data width (for example, 0x80 becomes 0xFFFFFF80).
- R7: valid_o and flag_we_o are both high in the same cycle exactly when the word is one of the nine patterns above. Any other word leaves flag_o unchanged.
- R8: A synchronous active-high rst clears flag_o to 0 at the next rising edge. It overrides a compare presented in the same cycle.
- R9: rn_idx_o is always bits 11:8 of the word, and rm_idx_o is always bits 7:4.
- R10: The result of a compare appears on flag_o after exactly one rising edge, and the flag is 0 when the condition fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| insn_i | input | 16 | Instruction word |
| rn_data_i | input | DATA_W | Value of register n |
| rm_data_i | input | DATA_W | Value of register m |
| r0_data_i | input | DATA_W | Value of register 0 |
| rn_idx_o | output | 4 | Index of register n |
| rm_idx_o | output | 4 | Index of register m |
| valid_o | output | 1 | Word is a recognised compare |
| flag_we_o | output | 1 | Flag write enable |
| flag_o | output | 1 | Registered condition flag |

## Verification
The bench builds the block with its default 32-bit data width, which gives four 8-bit lanes. At this width the decode can be swept over all 65,536 instruction words. The sweep confirms that exactly the nine patterns raise valid and that every other word holds the flag. Every pairing of eight boundary operands is then run through each register form, including the most negative and most positive values and equal pairs. Finally, all 256 immediates are tried against both their sign-extended and zero-extended forms.

// File: rtl/cmpflag_pkg.sv
`timescale 1ns/1ps
package cmpflag_pkg;
    localparam int INSN_W = 16;
    localparam int IMM_W  = 8;
    localparam int IDX_W  = 4;

    typedef enum logic [3:0] {
        CK_NONE, CK_EQ, CK_SGE, CK_SGT, CK_UGT, CK_UGE,
        CK_POS, CK_NNEG, CK_LANE, CK_IMM
    } cmp_kind_e;

    typedef struct packed {
        logic flag;
    } flag_state_t;
endpackage

// File: rtl/cmpflag_decode.sv
`timescale 1ns/1ps
module cmpflag_decode
    import cmpflag_pkg::*;
(
    input  logic [INSN_W-1:0] insn_i,
    output cmp_kind_e         kind_o,
    output logic [IDX_W-1:0]  rn_idx_o,
    output logic [IDX_W-1:0]  rm_idx_o,
    output logic              valid_o
);
    logic [3:0] top_nib;
    logic [3:0] low_nib;

    always_comb begin
        top_nib  = insn_i[15:12];
        low_nib  = insn_i[3:0];
        rn_idx_o = insn_i[11:8];
        rm_idx_o = insn_i[7:4];
        kind_o   = CK_NONE;
        if (top_nib == 4'h3) begin
            case (low_nib)
                4'h0:    kind_o = CK_EQ;
                4'h3:    kind_o = CK_SGE;
                4'h7:    kind_o = CK_SGT;
                4'h6:    kind_o = CK_UGT;
                4'h2:    kind_o = CK_UGE;
                default: kind_o = CK_NONE;
            endcase
        end else if (top_nib == 4'h4) begin
            if (insn_i[7:0] == 8'h15)      kind_o = CK_POS;
            else if (insn_i[7:0] == 8'h11) kind_o = CK_NNEG;
        end else if (top_nib == 4'h2) begin
            if (low_nib == 4'hC) kind_o = CK_LANE;
        end else if (insn_i[15:8] == 8'h88) begin
            kind_o = CK_IMM;
        end
        valid_o = (kind_o != CK_NONE);
    end
endmodule

// File: rtl/cmpflag_eval.sv
`timescale 1ns/1ps
module cmpflag_eval
    import cmpflag_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANE_W = 8
) (
    input  cmp_kind_e         kind_i,
    input  logic [DATA_W-1:0] rn_i,
    input  logic [DATA_W-1:0] rm_i,
    input  logic [DATA_W-1:0] r0_i,
    input  logic [IMM_W-1:0]  imm_i,
    output logic              result_o
);
    localparam int LANES = DATA_W / LANE_W;

    logic [LANES-1:0]  lane_hit;
    logic [DATA_W-1:0] imm_ext;
    logic              rn_neg;
    logic              rn_zero;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_hit[g] = (rn_i[g*LANE_W +: LANE_W] == rm_i[g*LANE_W +: LANE_W]);
    end

    always_comb begin
        imm_ext  = {{(DATA_W-IMM_W){imm_i[IMM_W-1]}}, imm_i};
        rn_neg   = rn_i[DATA_W-1];
        rn_zero  = (rn_i == '0);
        result_o = 1'b0;
        case (kind_i)
            CK_EQ:   result_o = (rn_i == rm_i);
            CK_SGE:  result_o = ($signed(rn_i) >= $signed(rm_i));
            CK_SGT:  result_o = ($signed(rn_i) >  $signed(rm_i));
            CK_UGT:  result_o = (rn_i > rm_i);
            CK_UGE:  result_o = (rn_i >= rm_i);
            CK_POS:  result_o = !rn_neg && !rn_zero;
            CK_NNEG: result_o = !rn_neg;
            CK_LANE: result_o = |lane_hit;
            CK_IMM:  result_o = (r0_i == imm_ext);
            default: result_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/cmpflag_unit.sv
`timescale 1ns/1ps
module cmpflag_unit
    import cmpflag_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [15:0]       insn_i,
    input  logic [DATA_W-1:0] rn_data_i,
    input  logic [DATA_W-1:0] rm_data_i,
    input  logic [DATA_W-1:0] r0_data_i,
    output logic [3:0]        rn_idx_o,
    output logic [3:0]        rm_idx_o,
    output logic              valid_o,
    output logic              flag_we_o,
    output logic              flag_o
);
    cmp_kind_e   kind;
    logic        result;
    logic        is_cmp;
    flag_state_t state_d, state_q;

    cmpflag_decode u_decode (
        .insn_i   (insn_i),
        .kind_o   (kind),
        .rn_idx_o (rn_idx_o),
        .rm_idx_o (rm_idx_o),
        .valid_o  (is_cmp)
    );

    cmpflag_eval #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_eval (
        .kind_i   (kind),
        .rn_i     (rn_data_i),
        .rm_i     (rm_data_i),
        .r0_i     (r0_data_i),
        .imm_i    (insn_i[IMM_W-1:0]),
        .result_o (result)
    );

    always_comb begin
        state_d = state_q;
        if (is_cmp) state_d.flag = result;
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

    assign valid_o   = is_cmp;
    assign flag_we_o = is_cmp;
    assign flag_o    = state_q.flag;
endmodule

// File: rtl/cmpflag_checker.sv
`timescale 1ns/1ps
module cmpflag_checker #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic [15:0]       insn_i,
    input logic [DATA_W-1:0] rn_data_i,
    input logic [DATA_W-1:0] rm_data_i,
    input logic [DATA_W-1:0] r0_data_i,
    input logic              valid_o,
    input logic              flag_we_o,
    input logic              flag_o
);
    assert_reset_clear_R8: assert property (@(posedge clk) rst |=> !flag_o);

    assert_we_tracks_valid_R7: assert property (@(posedge clk) disable iff (rst)
        flag_we_o == valid_o);

    assert_hold_when_idle_R7: assert property (@(posedge clk) disable iff (rst)
        !flag_we_o |=> flag_o == $past(flag_o));

    assert_equal_form_R1: assert property (@(posedge clk) disable iff (rst)
        (valid_o && insn_i[15:12] == 4'h3 && insn_i[3:0] == 4'h0)
        |=> flag_o == ($past(rn_data_i) == $past(rm_data_i)));

    assert_nonneg_form_R4: assert property (@(posedge clk) disable iff (rst)
        (valid_o && insn_i[15:12] == 4'h4 && insn_i[7:0] == 8'h11)
        |=> flag_o == !$past(rn_data_i[DATA_W-1]));

    assert_imm_form_R6: assert property (@(posedge clk) disable iff (rst)
        (valid_o && insn_i[15:8] == 8'h88)
        |=> flag_o == ($past(r0_data_i) ==
                       {{(DATA_W-8){$past(insn_i[7])}}, $past(insn_i[7:0])}));
endmodule

bind cmpflag_unit cmpflag_checker #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .insn_i    (insn_i),
    .rn_data_i (rn_data_i),
    .rm_data_i (rm_data_i),
    .r0_data_i (r0_data_i),
    .valid_o   (valid_o),
    .flag_we_o (flag_we_o),
    .flag_o    (flag_o)
);

// File: tb/cmpflag_unit_bench.sv
`timescale 1ns/1ps
module cmpflag_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] insn = 16'h0009;
    logic [31:0] rn = '0, rm = '0, r0 = '0;
    logic [3:0]  rn_idx, rm_idx;
    logic        valid, flag_we, flag;

    int n_checks = 0;
    int n_fails  = 0;
    logic exp_flag = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cmpflag_unit u_cmpflag_unit (
        .clk(clk), .rst(rst), .insn_i(insn),
        .rn_data_i(rn), .rm_data_i(rm), .r0_data_i(r0),
        .rn_idx_o(rn_idx), .rm_idx_o(rm_idx),
        .valid_o(valid), .flag_we_o(flag_we), .flag_o(flag)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s insn=%h actual=%h expected=%h", req, insn, act, exp);
        end
    endtask

    // returns {is_compare, condition}
    function automatic logic [1:0] model(input logic [15:0] w, input logic [31:0] a, input logic [31:0] b, input logic [31:0] z);
        logic signed [31:0] sa, sb;
        logic signed [7:0]  si;
        logic [31:0] ext;
        logic hit;
        sa = a; sb = b; si = w[7:0];
        ext = 32'(int'(si));
        hit = 1'b0;
        for (int k = 0; k < 4; k++) if (a[8*k +: 8] == b[8*k +: 8]) hit = 1'b1;
        casez (w)
            16'b0011_????_????_0000: return {1'b1, a == b};
            16'b0011_????_????_0011: return {1'b1, sa >= sb};
            16'b0011_????_????_0111: return {1'b1, sa > sb};
            16'b0011_????_????_0110: return {1'b1, a > b};
            16'b0011_????_????_0010: return {1'b1, a >= b};
            16'b0100_????_0001_0101: return {1'b1, sa > 0};
            16'b0100_????_0001_0001: return {1'b1, sa >= 0};
            16'b0010_????_????_1100: return {1'b1, hit};
            16'b1000_1000_????_????: return {1'b1, z == ext};
            default:                 return 2'b00;
        endcase
    endfunction

    function automatic string tag_of(input logic [15:0] w);
        casez (w)
            16'b0011_????_????_0000: return "R1";
            16'b0011_????_????_0?11: return "R2";
            16'b0011_????_????_0110,
            16'b0011_????_????_0010: return "R3";
            16'b0100_????_0001_0?01: return "R4";
            16'b0010_????_????_1100: return "R5";
            16'b1000_1000_????_????: return "R6";
            default:                 return "R7";
        endcase
    endfunction

    task automatic apply(input logic [15:0] w, input logic [31:0] a, input logic [31:0] b, input logic [31:0] z);
        logic [1:0] m;
        @(negedge clk);
        insn = w; rn = a; rm = b; r0 = z;
        #1;
        m = model(w, a, b, z);
        check(valid === m[1], "R7", 32'(valid), 32'(m[1]));
        check(flag_we === m[1], "R7", 32'(flag_we), 32'(m[1]));
        check(rn_idx === w[11:8] && rm_idx === w[7:4], "R9", {24'h0, rn_idx, rm_idx}, {24'h0, w[11:4]});
        if (m[1]) exp_flag = m[0];
        @(posedge clk); #1;
        // R10: result visible after exactly one edge
        check(flag === exp_flag, tag_of(w), 32'(flag), 32'(exp_flag));
    endtask

    localparam logic [15:0] OP_EQ = 16'h3120, OP_SGE = 16'h3123, OP_SGT = 16'h3127;
    localparam logic [15:0] OP_UGT = 16'h3126, OP_UGE = 16'h3122, OP_POS = 16'h4115;
    localparam logic [15:0] OP_NNEG = 16'h4111, OP_LANE = 16'h212C;

    initial begin
        logic [31:0] vals [8];
        logic [15:0] ops [8];
        vals = '{32'h0, 32'h1, 32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF,
                 32'h1234_5678, 32'h12AA_BBCC, 32'hFF00_0001};
        ops  = '{OP_EQ, OP_SGE, OP_SGT, OP_UGT, OP_UGE, OP_POS, OP_NNEG, OP_LANE};

        repeat (3) @(posedge clk);
        #1;
        check(flag === 1'b0, "R8", 32'(flag), 32'h0);
        @(negedge clk); rst = 1'b0;

        // Corner cases
        apply(OP_SGE, 32'h8000_0000, 32'h7FFF_FFFF, 0);   // R2 -> 0
        apply(OP_UGE, 32'h8000_0000, 32'h7FFF_FFFF, 0);   // R3 -> 1
        apply(OP_SGT, 32'h5555_5555, 32'h5555_5555, 0);   // R2 equal -> 0
        apply(OP_SGE, 32'h5555_5555, 32'h5555_5555, 0);   // R2 equal -> 1
        apply(OP_UGT, 32'h5555_5555, 32'h5555_5555, 0);   // R3 equal -> 0
        apply(OP_UGE, 32'h5555_5555, 32'h5555_5555, 0);   // R3 equal -> 1
        apply(16'h8880, 0, 0, 32'hFFFF_FF80);             // R6 -> 1
        apply(16'h8880, 0, 0, 32'h0000_0080);             // R6 -> 0
        apply(OP_LANE, 32'h1234_5678, 32'h12AA_BBCC, 0);  // R5 top lane only -> 1
        apply(OP_LANE, 32'h1234_5678, 32'h21AA_BBCC, 0);  // R5 no lane -> 0

        // Register forms over all operand pairs
        for (int o = 0; o < 8; o++)
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 8; j++)
                    apply(ops[o], vals[i], vals[j], 0);

        // Immediate form: every immediate against sign- and zero-extended R0
        for (int v = 0; v < 256; v++) begin
            apply(16'h8800 | 16'(v), 0, 0, 32'(int'($signed(8'(v)))));
            apply(16'h8800 | 16'(v), 0, 0, 32'(v));
        end

        // R7 hold: set flag, then a non-compare word leaves it
        apply(OP_EQ, 7, 7, 0);
        apply(16'h0009, 1, 2, 3);
        apply(OP_EQ, 7, 8, 0);
        apply(16'h3121, 1, 1, 0);

        // Full decode sweep
        for (int w = 0; w < 65536; w++)
            apply(16'(w), 32'h0, 32'h0, 32'h0);

        // R8: reset overrides a compare that would set the flag
        apply(OP_EQ, 5, 5, 0);
        @(negedge clk);
        rst = 1'b1; insn = OP_EQ; rn = 9; rm = 9;
        @(posedge clk); #1;
        check(flag === 1'b0, "R8", 32'(flag), 32'h0);
        @(negedge clk); rst = 1'b0;

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        #950000;
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end
endmodule